// File: doc/BRIEF.md
# Thermal brightness derating controller

This block scales down the brightness an LED driver delivers when things get hot. It looks at a die temperature code. Once that temperature passes a selectable limit, it cuts the PWM duty by a fixed fraction for every degree of excess. In hybrid dimming it cuts the LED current by the same fraction. It also watches three comparator results from an external thermistor front end:

- A "low level crossed" result reduces LED current.
- A "high level crossed" result requests that all LED outputs be switched off.
- An "open sensor" result reports a missing thermistor and has no effect on brightness.

The derated duty and current are loaded only on a PWM period strobe, so a running PWM period never changes half way through. The off request and the status flags react without waiting for the PWM period. Each external comparator result is debounced before it has any effect. Each one sets a sticky flag. A flag clears only when a clear strobe arrives after the condition has gone away. The measurement front ends for temperature and resistance sit outside the block. The 4-bit resistance codes for the two external levels are programmed there. In that code space, 0000 is the highest resistance (79.67 kΩ) and 1111 the lowest (5.87 kΩ).

Top module: `thermal_derate`

## Requirements
- R1: The limit select maps as follows: 2'b00 disables the thermal derating, 2'b01 sets a limit of 90 °C, 2'b10 sets 100 °C and 2'b11 sets 110 °C. The excess is die_temp minus the limit when die_temp is greater than the limit. In every other case the excess is 0.
- R2: The derating factor is factor = 65536 − 1475 × excess, clamped to 0 when that value would be negative. This is 2.25 % per °C in Q16. The duty loaded at a period strobe is (duty_req × factor) >> 16. With no excess the duty passes through exactly, and from 45 °C of excess the duty is 0.
- R3: When hybrid_en is 1, the current loaded at a period strobe is (cur_req × factor) >> 16. When hybrid_en is 0, the current is cur_req unchanged by temperature.
- R4: duty_out and cur_out change only on the clock edge where period_stb is 1. They take the values computed from the inputs present at that edge, and they hold between strobes.
- R5: ext_low_hit must be sampled high on 4 consecutive clock edges before it takes effect. The low condition then becomes active on the 4th of those edges. Any edge sampling it low deactivates it. While the low condition is active, every period update shifts the current right by 1, so the current is halved after any hybrid derating. flag_low sets one edge after the condition becomes active.
- R6: ext_high_hit uses the same 4-edge debounce. all_off equals the active high condition, with no wait for a strobe. A period update made while all_off is 1 loads duty 0 and current 0. flag_high sets one edge after all_off rises.
- R7: ext_open becomes active after 8 consecutive high samples. flag_missing sets one edge later. It never changes all_off, duty_out or cur_out.
- R8: Each flag is sticky. clear_stb clears a flag only if that flag's condition is inactive. A clear that arrives while the condition is active leaves the flag at 1.
- R9: While ext_en is 0, all three comparator inputs are ignored. One edge after ext_en is 0, all three flags and all_off are 0, and later period updates apply no current halving and no forced zero.
- R10: While rst_n is 0, duty_out, cur_out, all_off and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_stb | input | 1 | PWM period boundary; loads new outputs |
| die_temp | input | 8 | Die temperature, unsigned °C |
| limit_sel | input | 2 | Thermal limit select |
| hybrid_en | input | 1 | Hybrid PWM/current dimming mode |
| duty_req | input | 12 | Requested PWM duty |
| cur_req | input | 12 | Requested LED current |
| ext_low_hit | input | 1 | Thermistor below low-level resistance |
| ext_high_hit | input | 1 | Thermistor below high-level resistance |
| ext_open | input | 1 | Thermistor resistance above 2 MΩ |
| ext_en | input | 1 | External thermistor checks enable |
| clear_stb | input | 1 | Flag clear request |
| duty_out | output | 12 | Derated PWM duty |
| cur_out | output | 12 | Derated LED current |
| all_off | output | 1 | Request to switch all LED outputs off |
| flag_low | output | 1 | Sticky low-level flag |
| flag_high | output | 1 | Sticky high-level flag |
| flag_missing | output | 1 | Sticky missing-sensor flag |

## Verification
The properties assume that period_stb and clear_stb are held low through reset. They also assume that ext_en changes only at clock edges, in the same way as every other input. Any input may move between strobes; the properties only require that the outputs stay still in that time.

The bench drives every input half a cycle away from the sampling edge. It holds each comparator input for counted edge windows, placed just below and just at the debounce length. It raises a strobe only after the debounced condition it is testing has settled, so each expected value depends on one known condition state.

// File: rtl/thd_pkg.sv
package thd_pkg;

    // index of each external sensor channel in the condition vectors
    typedef enum int unsigned {
        CH_LOW  = 0,
        CH_HIGH = 1,
        CH_MISS = 2
    } thd_chan_e;

    localparam int unsigned NUM_CH = 3;

    // thermal limit select codes
    typedef enum logic [1:0] {
        LIM_OFF = 2'b00,
        LIM_A   = 2'b01,
        LIM_B   = 2'b10,
        LIM_C   = 2'b11
    } thd_limit_e;

endpackage

// File: rtl/thd_ext_chan.sv
// Debounce for one comparator: active after FILT consecutive high samples.
module thd_ext_chan #(
    parameter int unsigned FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic active
);
    localparam int unsigned CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(FILT);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!raw) begin
            st_d.cnt = '0;
            st_d.act = 1'b0;
        end else begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.act = (st_q.cnt >= CNT_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;

endmodule

// File: rtl/thd_factor.sv
// Computes the Q(FRAC_W) derating factor from temperature and limit.
module thd_factor
    import thd_pkg::*;
#(
    parameter int unsigned TEMP_W  = 8,
    parameter int unsigned FRAC_W  = 16,
    parameter int unsigned LIMIT_A = 90,
    parameter int unsigned LIMIT_B = 100,
    parameter int unsigned LIMIT_C = 110
) (
    input  logic [TEMP_W-1:0] die_temp,
    input  logic [1:0]        limit_sel,
    output logic [FRAC_W:0]   factor
);
    // 2.25 % per degree, rounded to the nearest Q(FRAC_W) step
    localparam int unsigned STEP   = (225 * (2 ** FRAC_W) + 5000) / 10000;
    localparam int unsigned STEP_W = $clog2(STEP + 1);
    localparam int unsigned PROD_W = (TEMP_W + STEP_W > FRAC_W + 1) ?
                                     (TEMP_W + STEP_W) : (FRAC_W + 1);
    localparam logic [PROD_W-1:0] ONE_P  = PROD_W'(2 ** FRAC_W);
    localparam logic [PROD_W-1:0] STEP_P = PROD_W'(STEP);

    logic [TEMP_W-1:0] limit_val;
    logic              limit_on;
    logic [TEMP_W-1:0] excess;
    logic [PROD_W-1:0] cut;

    always_comb begin
        limit_on  = 1'b1;
        limit_val = TEMP_W'(LIMIT_A);
        case (thd_limit_e'(limit_sel))
            LIM_OFF: begin
                limit_on  = 1'b0;
                limit_val = '0;
            end
            LIM_A:   limit_val = TEMP_W'(LIMIT_A);
            LIM_B:   limit_val = TEMP_W'(LIMIT_B);
            LIM_C:   limit_val = TEMP_W'(LIMIT_C);
            default: limit_val = TEMP_W'(LIMIT_A);
        endcase

        if (limit_on && (die_temp > limit_val)) begin
            excess = die_temp - limit_val;
        end else begin
            excess = '0;
        end

        cut = PROD_W'(excess) * STEP_P;

        if (cut >= ONE_P) begin
            factor = '0;
        end else begin
            factor = (FRAC_W + 1)'(ONE_P - cut);
        end
    end

endmodule

// File: rtl/thd_scale.sv
// Multiplies a value by a Q(FRAC_W) factor that never exceeds 1.0.
module thd_scale #(
    parameter int unsigned VAL_W  = 12,
    parameter int unsigned FRAC_W = 16
) (
    input  logic [VAL_W-1:0] val,
    input  logic [FRAC_W:0]  factor,
    output logic [VAL_W-1:0] scaled
);
    localparam int unsigned P_W = VAL_W + FRAC_W + 1;

    logic [P_W-1:0] prod;

    always_comb begin
        prod   = P_W'(val) * P_W'(factor);
        scaled = VAL_W'(prod >> FRAC_W);
    end

endmodule

// File: rtl/thermal_derate.sv
module thermal_derate
    import thd_pkg::*;
#(
    parameter int unsigned TEMP_W        = 8,
    parameter int unsigned DUTY_W        = 12,
    parameter int unsigned CUR_W         = 12,
    parameter int unsigned FRAC_W        = 16,
    parameter int unsigned LIMIT_A       = 90,
    parameter int unsigned LIMIT_B       = 100,
    parameter int unsigned LIMIT_C       = 110,
    parameter int unsigned FILT_CYC      = 4,
    parameter int unsigned MISS_FILT_CYC = 8,
    parameter int unsigned LOW_CUT_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_stb,
    input  logic [TEMP_W-1:0] die_temp,
    input  logic [1:0]        limit_sel,
    input  logic              hybrid_en,
    input  logic [DUTY_W-1:0] duty_req,
    input  logic [CUR_W-1:0]  cur_req,
    input  logic              ext_low_hit,
    input  logic              ext_high_hit,
    input  logic              ext_open,
    input  logic              ext_en,
    input  logic              clear_stb,
    output logic [DUTY_W-1:0] duty_out,
    output logic [CUR_W-1:0]  cur_out,
    output logic              all_off,
    output logic              flag_low,
    output logic              flag_high,
    output logic              flag_missing
);

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic [CUR_W-1:0]  cur;
        logic [NUM_CH-1:0] flags;
    } top_t;

    logic [FRAC_W:0]   factor;
    logic [DUTY_W-1:0] duty_scaled;
    logic [CUR_W-1:0]  cur_scaled;
    logic [NUM_CH-1:0] raw_cond;
    logic [NUM_CH-1:0] cond_act;
    logic [CUR_W-1:0]  cur_sel;

    top_t st_d, st_q;

    thd_factor #(
        .TEMP_W  (TEMP_W),
        .FRAC_W  (FRAC_W),
        .LIMIT_A (LIMIT_A),
        .LIMIT_B (LIMIT_B),
        .LIMIT_C (LIMIT_C)
    ) u_factor (
        .die_temp  (die_temp),
        .limit_sel (limit_sel),
        .factor    (factor)
    );

    thd_scale #(.VAL_W(DUTY_W), .FRAC_W(FRAC_W)) u_scale_duty (
        .val    (duty_req),
        .factor (factor),
        .scaled (duty_scaled)
    );

    thd_scale #(.VAL_W(CUR_W), .FRAC_W(FRAC_W)) u_scale_cur (
        .val    (cur_req),
        .factor (factor),
        .scaled (cur_scaled)
    );

    // gated comparator inputs, ordered by channel index
    always_comb begin
        raw_cond          = '0;
        raw_cond[CH_LOW]  = ext_low_hit  & ext_en;
        raw_cond[CH_HIGH] = ext_high_hit & ext_en;
        raw_cond[CH_MISS] = ext_open     & ext_en;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        localparam int unsigned CH_FILT = (g == CH_MISS) ? MISS_FILT_CYC : FILT_CYC;
        thd_ext_chan #(.FILT(CH_FILT)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw_cond[g]),
            .active (cond_act[g])
        );
    end

    always_comb begin
        st_d = st_q;

        // sticky flags: set while the condition is active, clear only after it is gone
        for (int i = 0; i < NUM_CH; i++) begin
            st_d.flags[i] = ext_en & (cond_act[i] | (st_q.flags[i] & ~clear_stb));
        end

        cur_sel = hybrid_en ? cur_scaled : cur_req;
        if (cond_act[CH_LOW]) begin
            cur_sel = cur_sel >> LOW_CUT_SHIFT;
        end

        if (period_stb) begin
            if (cond_act[CH_HIGH]) begin
                st_d.duty = '0;
                st_d.cur  = '0;
            end else begin
                st_d.duty = duty_scaled;
                st_d.cur  = cur_sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_out     = st_q.duty;
    assign cur_out      = st_q.cur;
    assign all_off      = cond_act[CH_HIGH];
    assign flag_low     = st_q.flags[CH_LOW];
    assign flag_high    = st_q.flags[CH_HIGH];
    assign flag_missing = st_q.flags[CH_MISS];

endmodule

// File: rtl/thd_checker.sv
module thd_checker #(
    parameter int unsigned DUTY_W = 12,
    parameter int unsigned CUR_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              period_stb,
    input logic [DUTY_W-1:0] duty_req,
    input logic              ext_en,
    input logic              clear_stb,
    input logic [DUTY_W-1:0] duty_out,
    input logic [CUR_W-1:0]  cur_out,
    input logic              all_off,
    input logic              flag_low,
    input logic              flag_high,
    input logic              flag_missing
);

    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_stb) |-> ($stable(duty_out) && $stable(cur_out)));

    assert_duty_not_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(period_stb) |-> (duty_out <= $past(duty_req)));

    assert_off_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(period_stb) && $past(all_off)) |-> (duty_out == '0 && cur_out == '0));

    assert_off_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (all_off && ext_en) |=> flag_high);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |=> (!flag_low && !flag_high && !flag_missing && !all_off));

    assert_flag_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_low) |-> ($past(clear_stb) || !$past(ext_en)));

    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (duty_out == '0 && cur_out == '0 && !flag_high)));

endmodule

bind thermal_derate thd_checker #(.DUTY_W(DUTY_W), .CUR_W(CUR_W)) u_thd_chk (.*);

// File: tb/thermal_derate_test.sv
module thermal_derate_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        period_stb;
    logic [7:0]  die_temp;
    logic [1:0]  limit_sel;
    logic        hybrid_en;
    logic [11:0] duty_req;
    logic [11:0] cur_req;
    logic        ext_low_hit;
    logic        ext_high_hit;
    logic        ext_open;
    logic        ext_en;
    logic        clear_stb;
    logic [11:0] duty_out;
    logic [11:0] cur_out;
    logic        all_off;
    logic        flag_low;
    logic        flag_high;
    logic        flag_missing;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    thermal_derate uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_stb   (period_stb),
        .die_temp     (die_temp),
        .limit_sel    (limit_sel),
        .hybrid_en    (hybrid_en),
        .duty_req     (duty_req),
        .cur_req      (cur_req),
        .ext_low_hit  (ext_low_hit),
        .ext_high_hit (ext_high_hit),
        .ext_open     (ext_open),
        .ext_en       (ext_en),
        .clear_stb    (clear_stb),
        .duty_out     (duty_out),
        .cur_out      (cur_out),
        .all_off      (all_off),
        .flag_low     (flag_low),
        .flag_high    (flag_high),
        .flag_missing (flag_missing)
    );

    always #5 clk = ~clk;

    function automatic int lim_of(int sel);
        case (sel)
            1: return 90;
            2: return 100;
            3: return 110;
            default: return -1;
        endcase
    endfunction

    function automatic longint fac_of(int sel, int t);
        longint ex;
        longint f;
        ex = 0;
        if (lim_of(sel) >= 0 && t > lim_of(sel)) ex = t - lim_of(sel);
        f = 65536 - 1475 * ex;
        if (f < 0) f = 0;
        return f;
    endfunction

    function automatic int scale_of(int v, int sel, int t);
        return int'((longint'(v) * fac_of(sel, t)) >>> 16);
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // one period strobe; returns at the negedge after the loading edge
    task automatic update();
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        period_stb   = 1'b0;
        die_temp     = 8'd25;
        limit_sel    = 2'b00;
        hybrid_en    = 1'b0;
        duty_req     = 12'd4095;
        cur_req      = 12'd3000;
        ext_low_hit  = 1'b0;
        ext_high_hit = 1'b0;
        ext_open     = 1'b0;
        ext_en       = 1'b0;
        clear_stb    = 1'b0;
        cycles(3);
        check("R10 duty", int'(duty_out), 0);
        check("R10 cur", int'(cur_out), 0);
        check("R10 flags", int'({all_off, flag_low, flag_high, flag_missing}), 0);
        rst_n = 1'b1;
        cycles(1);

        // R1 R2 R3: full temperature sweep for every limit code, hybrid mode
        hybrid_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 256; t++) begin
                limit_sel = s[1:0];
                die_temp  = t[7:0];
                update();
                check("R1/R2 duty sweep", int'(duty_out), scale_of(4095, s, t));
                check("R3 hybrid cur sweep", int'(cur_out), scale_of(3000, s, t));
            end
        end

        // R2: duty value sweep at a fixed excess
        limit_sel = 2'b10;
        die_temp  = 8'd120;
        for (int d = 0; d < 4096; d += 37) begin
            duty_req = d[11:0];
            update();
            check("R2 duty value sweep", int'(duty_out), scale_of(d, 2, 120));
        end

        // R3: non-hybrid current passes unchanged
        hybrid_en = 1'b0;
        limit_sel = 2'b11;
        die_temp  = 8'd150;
        duty_req  = 12'd2000;
        cur_req   = 12'd1234;
        update();
        check("R3 non-hybrid cur", int'(cur_out), 1234);
        check("R3 non-hybrid duty", int'(duty_out), scale_of(2000, 3, 150));

        // R4: inputs move without a strobe; outputs hold
        duty_req = 12'd100;
        cur_req  = 12'd50;
        die_temp = 8'd20;
        cycles(5);
        check("R4 hold duty", int'(duty_out), scale_of(2000, 3, 150));
        check("R4 hold cur", int'(cur_out), 1234);
        update();
        check("R4 load duty", int'(duty_out), 100);

        // R5: low-level debounce and current halving
        ext_en      = 1'b1;
        duty_req    = 12'd3000;
        cur_req     = 12'd1000;
        ext_low_hit = 1'b1;
        cycles(3);
        ext_low_hit = 1'b0;
        cycles(2);
        check("R5 short pulse no flag", int'(flag_low), 0);
        update();
        check("R5 short pulse no cut", int'(cur_out), 1000);
        ext_low_hit = 1'b1;
        cycles(4);
        check("R5 flag one edge later", int'(flag_low), 0);
        cycles(1);
        check("R5 flag set", int'(flag_low), 1);
        update();
        check("R5 cur halved", int'(cur_out), 500);
        check("R5 duty kept", int'(duty_out), 3000);

        // R8: clear ignored while active, effective after condition goes
        clear_stb = 1'b1;
        cycles(1);
        clear_stb = 1'b0;
        cycles(1);
        check("R8 clear while active", int'(flag_low), 1);
        ext_low_hit = 1'b0;
        cycles(2);
        check("R8 sticky after gone", int'(flag_low), 1);
        update();
        check("R5 cut released", int'(cur_out), 1000);
        clear_stb = 1'b1;
        cycles(1);
        clear_stb = 1'b0;
        check("R8 cleared", int'(flag_low), 0);

        // R6: high-level off request
        ext_high_hit = 1'b1;
        cycles(3);
        check("R6 debounce all_off", int'(all_off), 0);
        cycles(1);
        check("R6 all_off", int'(all_off), 1);
        cycles(1);
        check("R6 flag_high", int'(flag_high), 1);
        update();
        check("R6 duty zero", int'(duty_out), 0);
        check("R6 cur zero", int'(cur_out), 0);
        ext_high_hit = 1'b0;
        cycles(1);
        check("R6 all_off released", int'(all_off), 0);
        update();
        check("R6 duty restored", int'(duty_out), 3000);
        clear_stb = 1'b1;
        cycles(1);
        clear_stb = 1'b0;
        check("R8 high cleared", int'(flag_high), 0);

        // R7: missing sensor flag with no effect on brightness
        ext_open = 1'b1;
        cycles(7);
        check("R7 debounce", int'(flag_missing), 0);
        cycles(2);
        check("R7 flag_missing", int'(flag_missing), 1);
        update();
        check("R7 duty untouched", int'(duty_out), 3000);
        check("R7 cur untouched", int'(cur_out), 1000);
        check("R7 all_off untouched", int'(all_off), 0);

        // R9: disabled checks ignore all comparators and clear flags
        ext_low_hit  = 1'b1;
        ext_high_hit = 1'b1;
        ext_en       = 1'b0;
        cycles(1);
        check("R9 flags cleared", int'({flag_low, flag_high, flag_missing}), 0);
        cycles(9);
        check("R9 all_off", int'(all_off), 0);
        check("R9 flags stay clear", int'({flag_low, flag_high, flag_missing}), 0);
        update();
        check("R9 duty not forced", int'(duty_out), 3000);
        check("R9 cur not halved", int'(cur_out), 1000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule